// File: doc/BRIEF.md
# Virtual Output Queue Receive Buffer

This block sits on one input port of a switch and stores incoming flits in a separate logical queue for every pairing of destination output and virtual channel. With the default settings there are 5 destinations and 4 channels, so the buffer keeps 20 queues. All queues draw slots from one shared storage array of 64 flits. Each queue is a linked list through a next-pointer array. Unused slots form a free stack that threads through the same pointer array.

The upstream sender writes one flit per cycle. Each write carries the flit's destination, its channel and an end-of-packet marker. Every non-empty queue raises its own bit in a head-valid vector, so the crossbar arbiter sees requests toward several outputs at the same time. A stalled head on one queue therefore never holds back flits that wait in another queue. When the crossbar grants a queue, it names that queue on the dequeue port and takes the head flit in the same cycle. The freed slot then returns one credit for its channel upstream. A write that arrives with no credit left for its channel, or with an invalid destination, is dropped and sets a sticky error flag.

Top module: `voq_buffer`

## Requirements
- R1: After reset, every head_valid_o bit is low, err_o is low and credit_valid_o is low.
- R2: Queue q = vc*NUM_OUT + out maps to bit q of head_valid_o. That bit is high exactly while the queue holds at least one flit. An accepted write makes the bit high after the next clock edge.
- R3: Each queue is first-in first-out. While deq_valid_i names a non-empty queue, deq_data_o and deq_last_o show that queue's oldest flit in the same cycle, and the edge removes it.
- R4: A queue that is never granted does not delay the writes to, or the dequeues from, any other queue.
- R5: When a queue is dequeued and written in the same cycle, the result is correct at any fill level, including a queue that holds exactly one flit.
- R6: Every dequeue that is carried out returns one credit: credit_valid_o is high in the following cycle, and credit_vc_o carries the channel of the dequeued queue.
- R7: A dequeue that names an empty queue, or a destination of NUM_OUT or above, returns no credit and leaves every queue unchanged.
- R8: A write to a channel that has no credit left is dropped, and err_o goes high and stays high until reset.
- R9: A write whose destination is NUM_OUT or above is dropped and sets err_o.
- R10: Each channel starts with INIT_CREDIT credits. After all queues drain, every credit has come back, so the upstream count per channel is INIT_CREDIT again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Flit write strobe |
| wr_data_i | input | DATA_W | Flit payload |
| wr_out_i | input | OUT_W | Destination output index |
| wr_vc_i | input | VC_W | Virtual channel index |
| wr_last_i | input | 1 | End-of-packet marker |
| head_valid_o | output | NUM_OUT*NUM_VC | Per-queue non-empty request vector |
| deq_valid_i | input | 1 | Crossbar grant, dequeue strobe |
| deq_out_i | input | OUT_W | Output index of granted queue |
| deq_vc_i | input | VC_W | Channel of granted queue |
| deq_data_o | output | DATA_W | Head flit payload of the granted queue |
| deq_last_o | output | 1 | Head flit end-of-packet marker |
| credit_valid_o | output | 1 | One credit returned upstream |
| credit_vc_o | output | VC_W | Channel of the returned credit |
| err_o | output | 1 | Sticky protocol error |

## Verification
The assertions rely on three input conditions. The upstream sender writes only against credits it actually holds. The total of INIT_CREDIT across all channels is no larger than the slot count, so the free stack is never popped while empty. A grant to an empty queue is a harmless no-op. The random stimulus keeps a per-channel credit count in the bench and raises a write only when that count is positive. Dequeues mostly name queues that the bench model holds as non-empty. Grants to empty or out-of-range queues, writes with no credit and writes to bad destinations appear only in the directed corner cases, which check the error flag and the dropped state.

// File: rtl/voq_pkg.sv
package voq_pkg;
  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/voq_credit_ctrl.sv
module voq_credit_ctrl
  import voq_pkg::*;
#(
  parameter int unsigned NUM_VC      = 4,
  parameter int unsigned INIT_CREDIT = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          take_i,
  input  logic [width_of(NUM_VC)-1:0]   take_vc_i,
  input  logic                          give_i,
  input  logic [width_of(NUM_VC)-1:0]   give_vc_i,
  output logic [NUM_VC-1:0]             has_credit_o
);
  localparam int unsigned VC_W  = width_of(NUM_VC);
  localparam int unsigned CNT_W = $clog2(INIT_CREDIT + 1);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CNT_W-1:0] cnt;
    logic take_hit, give_hit;
    assign take_hit = take_i && (take_vc_i == VC_W'(v));
    assign give_hit = give_i && (give_vc_i == VC_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt <= CNT_W'(INIT_CREDIT);
      else if (take_hit && !give_hit) cnt <= cnt - 1'b1;
      else if (give_hit && !take_hit) cnt <= cnt + 1'b1;
    end
    assign has_credit_o[v] = (cnt != '0);

    // R10
    cnt_le_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= CNT_W'(INIT_CREDIT));
    // R8
    no_take_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_hit |-> cnt != '0);
  end
endmodule

// File: rtl/voq_qstate.sv
module voq_qstate #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic             deq_i,
  input  logic [PTR_W-1:0] slot_i,
  input  logic [PTR_W-1:0] next_head_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             valid_o,
  output logic             link_o
);
  logic single, empties, restart;
  assign single  = valid_o && (head_o == tail_o);
  assign empties = deq_i && single;
  assign restart = enq_i && (!valid_o || empties);
  assign link_o  = enq_i && valid_o && !empties;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= enq_i || (valid_o && !empties);
      if (restart) begin
        head_o <= slot_i;
        tail_o <= slot_i;
      end else begin
        if (enq_i) tail_o <= slot_i;
        if (deq_i) head_o <= next_head_i;
      end
    end
  end

  // R2
  enq_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |=> valid_o);
  // R5
  last_out_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i && !enq_i && single) |=> !valid_o);
  // R7
  no_deq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> valid_o);
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer
  import voq_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 5,
  parameter int unsigned NUM_VC      = 4,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned INIT_CREDIT = 16,
  localparam int unsigned OUT_W      = width_of(NUM_OUT),
  localparam int unsigned VC_W       = width_of(NUM_VC),
  localparam int unsigned NQ         = NUM_OUT * NUM_VC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OUT_W-1:0]  wr_out_i,
  input  logic [VC_W-1:0]   wr_vc_i,
  input  logic              wr_last_i,
  output logic [NQ-1:0]     head_valid_o,
  input  logic              deq_valid_i,
  input  logic [OUT_W-1:0]  deq_out_i,
  input  logic [VC_W-1:0]   deq_vc_i,
  output logic [DATA_W-1:0] deq_data_o,
  output logic              deq_last_o,
  output logic              credit_valid_o,
  output logic [VC_W-1:0]   credit_vc_o,
  output logic              err_o
);
  localparam int unsigned PTR_W = width_of(DEPTH);
  localparam int unsigned Q_W   = width_of(NQ) + 1;

  initial assert (NUM_VC * INIT_CREDIT <= DEPTH);

  logic [DATA_W:0]    mem    [DEPTH];
  logic [PTR_W-1:0]   next_q [DEPTH];
  logic [PTR_W-1:0]   free_head;
  logic [PTR_W-1:0]   q_head [NQ];
  logic [PTR_W-1:0]   q_tail [NQ];
  logic [NQ-1:0]      q_valid, q_link;
  logic [NUM_VC-1:0]  has_credit;

  logic           wr_out_ok, deq_out_ok, wr_bad, wr_fire, deq_fire;
  logic [Q_W-1:0] wr_q, deq_q;
  logic [PTR_W-1:0] alloc, rel, deq_next;

  assign wr_out_ok  = (32'(wr_out_i)  < NUM_OUT);
  assign deq_out_ok = (32'(deq_out_i) < NUM_OUT);
  assign wr_q  = wr_out_ok  ? Q_W'(wr_vc_i)  * Q_W'(NUM_OUT) + Q_W'(wr_out_i)  : '0;
  assign deq_q = deq_out_ok ? Q_W'(deq_vc_i) * Q_W'(NUM_OUT) + Q_W'(deq_out_i) : '0;

  assign wr_bad   = wr_valid_i && (!wr_out_ok || !has_credit[wr_vc_i]);
  assign wr_fire  = wr_valid_i && !wr_bad;
  assign deq_fire = deq_valid_i && deq_out_ok && q_valid[deq_q];

  assign alloc    = free_head;
  assign rel      = q_head[deq_q];
  assign deq_next = next_q[rel];
  assign {deq_last_o, deq_data_o} = mem[rel];
  assign head_valid_o = q_valid;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    voq_qstate #(.PTR_W(PTR_W)) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enq_i       (wr_fire && (wr_q == Q_W'(q))),
      .deq_i       (deq_fire && (deq_q == Q_W'(q))),
      .slot_i      (alloc),
      .next_head_i (deq_next),
      .head_o      (q_head[q]),
      .tail_o      (q_tail[q]),
      .valid_o     (q_valid[q]),
      .link_o      (q_link[q])
    );
  end

  voq_credit_ctrl #(.NUM_VC(NUM_VC), .INIT_CREDIT(INIT_CREDIT)) u_credit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (wr_fire),
    .take_vc_i    (wr_vc_i),
    .give_i       (deq_fire),
    .give_vc_i    (deq_vc_i),
    .has_credit_o (has_credit)
  );

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem[alloc] <= {wr_last_i, wr_data_i};
  end

  // Free slots form a stack threaded through next_q; a freed slot is pushed on top.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) next_q[i] <= PTR_W'(i + 1);
      free_head <= '0;
    end else begin
      if (wr_fire && q_link[wr_q]) next_q[q_tail[wr_q]] <= alloc;
      if (deq_fire) begin
        next_q[rel] <= wr_fire ? next_q[alloc] : free_head;
        free_head   <= rel;
      end else if (wr_fire) begin
        free_head <= next_q[alloc];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_valid_o <= 1'b0;
      credit_vc_o    <= '0;
      err_o          <= 1'b0;
    end else begin
      credit_valid_o <= deq_fire;
      credit_vc_o    <= deq_vc_i;
      err_o          <= err_o || wr_bad;
    end
  end

  // R6
  credit_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_fire |=> credit_valid_o && credit_vc_o == $past(deq_vc_i));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R9
  bad_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> err_o);
  // R5
  alloc_not_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && deq_fire) |-> alloc != rel);
endmodule

// File: tb/tb_voq_buffer.sv
module tb_voq_buffer;
  localparam int NOUT = 5, NVC = 4, DW = 16, INIT = 16, NQ = NOUT * NVC;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_valid, wr_last, deq_valid;
  logic [DW-1:0] wr_data;
  logic [2:0]    wr_out, deq_out;
  logic [1:0]    wr_vc, deq_vc;
  logic [NQ-1:0] head_valid;
  logic [DW-1:0] deq_data;
  logic          deq_last, credit_valid, err;
  logic [1:0]    credit_vc;

  voq_buffer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_out_i(wr_out),
    .wr_vc_i(wr_vc), .wr_last_i(wr_last), .head_valid_o(head_valid),
    .deq_valid_i(deq_valid), .deq_out_i(deq_out), .deq_vc_i(deq_vc),
    .deq_data_o(deq_data), .deq_last_o(deq_last),
    .credit_valid_o(credit_valid), .credit_vc_o(credit_vc), .err_o(err)
  );

  logic [DW:0] mq [NQ][$];
  int credit [NVC];
  bit exp_err;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NQ-1:0] model_vec();
    logic [NQ-1:0] v;
    for (int q = 0; q < NQ; q++) v[q] = (mq[q].size() > 0);
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_valid = 0; deq_valid = 0; wr_data = 0; wr_out = 0; wr_vc = 0;
    wr_last = 0; deq_out = 0; deq_vc = 0;
    for (int q = 0; q < NQ; q++) mq[q].delete();
    for (int v = 0; v < NVC; v++) credit[v] = INIT;
    exp_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 head_valid", 64'(head_valid), 64'(0));
    chk("R1 err", 64'(err), 64'(0));
    chk("R1 credit_valid", 64'(credit_valid), 64'(0));
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input bit wv, input int wd, input int wo, input int wvc, input bit wl,
                      input bit dv, input int dout, input int dvc);
    int dq; bit deq_real, wr_ok;
    wr_valid = wv; wr_data = DW'(wd); wr_out = 3'(wo); wr_vc = 2'(wvc); wr_last = wl;
    deq_valid = dv; deq_out = 3'(dout); deq_vc = 2'(dvc);
    #1;
    deq_real = 0; dq = 0;
    if (dv && dout < NOUT) begin
      dq = dvc * NOUT + dout;
      deq_real = (mq[dq].size() > 0);
    end
    if (deq_real) chk("R3 head flit", 64'({deq_last, deq_data}), 64'(mq[dq][0]));
    wr_ok = wv && wo < NOUT && credit[wvc] > 0;
    if (wv && !wr_ok) exp_err = 1;
    @(posedge clk);
    if (deq_real) void'(mq[dq].pop_front());
    if (wr_ok) begin
      mq[wvc * NOUT + wo].push_back({wl, DW'(wd)});
      credit[wvc]--;
    end
    @(negedge clk);
    wr_valid = 0; deq_valid = 0;
    chk("R6/R7 credit_valid", 64'(credit_valid), 64'(deq_real));
    if (deq_real) chk("R6 credit_vc", 64'(credit_vc), 64'(dvc));
    if (credit_valid) credit[credit_vc]++;
    chk("R2/R4 head_valid", 64'(head_valid), 64'(model_vec()));
    chk("R8/R9 err", 64'(err), 64'(exp_err));
  endtask

  task automatic drain();
    for (int q = 0; q < NQ; q++)
      while (mq[q].size() > 0) step(0, 0, 0, 0, 0, 1, q % NOUT, q / NOUT);
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R5: single-entry queue, dequeue and enqueue together
    step(1, 16'h1111, 2, 1, 0, 0, 0, 0);
    step(1, 16'h2222, 2, 1, 1, 1, 2, 1);
    chk("R5 single entry kept", 64'(head_valid[1*NOUT+2]), 64'(1));
    step(0, 0, 0, 0, 0, 1, 2, 1);
    // R7: dequeue of empty queue and of bad destination
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 16'h0abc, 4, 3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 7, 3);
    chk("R7 queue untouched", 64'(head_valid[3*NOUT+4]), 64'(1));
    step(0, 0, 0, 0, 0, 1, 4, 3);
    // R4: queue (vc0,out0) held while (vc0,out1) drains
    for (int i = 0; i < 3; i++) step(1, 16'h100 + i, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) step(1, 16'h200 + i, 1, 0, i, 0, 0, 0);
    step(1, 16'h300, 1, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R4 blocked queue still pending", 64'(head_valid[0]), 64'(1));
    step(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R4 other queue drained", 64'(head_valid[1]), 64'(0));
    // R5: multi-entry enqueue+dequeue on same queue
    step(1, 16'h400, 0, 0, 1, 1, 0, 0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      int wvc, wo, q; bit wv, dv;
      wvc = int'($urandom % NVC); wo = int'($urandom % NOUT);
      wv = ($urandom % 4 != 0) && credit[wvc] > 0;
      dv = ($urandom % 2 == 0);
      q = int'($urandom % NQ);
      if (mq[q].size() == 0)
        for (int k = 0; k < NQ; k++) if (mq[k].size() > 0) q = k;
      step(wv, int'($urandom % 65536), wo, wvc, bit'($urandom % 2), dv, q % NOUT, q / NOUT);
    end
    drain();
    for (int v = 0; v < NVC; v++) chk("R10 credits restored", 64'(credit[v]), 64'(INIT));
    chk("R8 no error so far", 64'(err), 64'(0));

    // R9: bad destination
    step(1, 16'hdead, 6, 0, 0, 0, 0, 0);
    chk("R9 dropped", 64'(head_valid), 64'(0));
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 sticky err", 64'(err), 64'(1));

    do_reset();
    // R8: exhaust channel 2 credits, then one more write
    for (int i = 0; i < INIT; i++) step(1, 16'h500 + i, 3, 2, 0, 0, 0, 0);
    chk("R8 err still low", 64'(err), 64'(0));
    step(1, 16'hbeef, 3, 2, 1, 0, 0, 0);
    chk("R8 err set", 64'(err), 64'(1));
    chk("R8 depth kept", 64'(mq[2*NOUT+3].size()), 64'(INIT));
    drain();
    chk("R8 err sticky", 64'(err), 64'(1));
    for (int v = 0; v < NVC; v++) chk("R10 credits back", 64'(credit[v]), 64'(INIT));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule